// File: doc/BRIEF.md
# Phase-Modulated Clock Line Codec

This block carries a serial bit stream over one wire as a clock whose rising edges stay strictly periodic. Each bit period starts with a rising edge. The data bit is carried only by where the falling edge lands. A 1 holds the line high for three quarters of the period. A 0 holds it high for one quarter. Because the rising edges never move, the far end can take a clean reference clock from the line with nothing more than an edge-triggered divider.

The transmitter runs from the block clock. Each quarter of a bit period lasts `DIV` clock cycles, so the block clock must be at least four times the bit rate. Source bits are offered with a valid/ready handshake, and one bit is taken per period. When no bit is offered, an alternating idle bit is sent so the edges never stop. The receiver takes the line from a wire, brings it through a two-flop synchroniser and counts how long the line stays high after each rising edge. It reports each decoded bit as a one-cycle pulse, and raises an error when the rising edges stop. A two-way link uses one transmitter and one receiver in each direction, which is two pins.

Top module: `pmc_link`

## Requirements
- R1: While `rst_n` is low, `tx_line` is 1 and `tx_ready`, `rx_valid` and `rx_err` are 0.
- R2: After reset `tx_line` rises once every 4*DIV clock cycles and is high for the first DIV cycles of every bit period.
- R3: In a period that carries bit 1, `tx_line` stays high for 3*DIV cycles and is then low for DIV cycles. In a period that carries bit 0, it is high for DIV cycles and then low for 3*DIV cycles.
- R4: `tx_ready` is 1 for exactly one cycle per bit period, the last cycle. A bit is taken when `tx_valid` and `tx_ready` are both 1, and it is sent in the period that follows. The period right after reset carries bit 0.
- R5: When `tx_valid` is 0 in the `tx_ready` cycle, the next period carries an idle bit. Idle bits alternate, starting with 1 for the first idle period after reset and flipping only on periods that are idle.
- R6: After a synchronised rising edge, the next synchronised falling edge produces a one-cycle `rx_valid` pulse. `rx_data` is 1 when the line was seen high for more than 2*DIV cycles, and 0 otherwise. Over a clean loop, the decoded bits equal the sent bits in order.
- R7: `rx_err` goes to 1 when no synchronised rising edge has been seen for 6*DIV cycles, and returns to 0 at the next rising edge. While `rx_err` is 1, no `rx_valid` pulse is produced.
- R8: `tx_data` has no effect on the line except in the cycle where the handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, 4*DIV cycles per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | A source bit is offered |
| tx_data | input | 1 | The offered bit |
| tx_ready | output | 1 | Bit is taken this cycle if valid |
| tx_line | output | 1 | Encoded line out |
| rx_line | input | 1 | Encoded line in (asynchronous) |
| rx_valid | output | 1 | One-cycle pulse per decoded bit |
| rx_data | output | 1 | Decoded bit, valid with rx_valid |
| rx_err | output | 1 | Rising edges have stopped |

## Verification
The transmitter is looped back into the receiver and driven with four kinds of stream. Runs of all ones and all zeros show that the two duty cycles come out distinct and that the threshold splits them. Alternating bits and a pseudo-random stream with gaps in `tx_valid` show that sent data and idle fill interleave correctly, and that the idle bit flips only on idle periods. While the handshake is idle, `tx_data` keeps changing, which shows that only the bit present at the handshake reaches the line. The wire is also held low for several periods and then released at a period boundary; this separates a timeout that latches from one that clears at the next edge, and checks that decoding picks up again cleanly afterwards.

// File: rtl/pmc_link.sv
module pmc_link #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_valid,
  input  logic tx_data,
  output logic tx_ready,
  output logic tx_line,
  input  logic rx_line,
  output logic rx_valid,
  output logic rx_data,
  output logic rx_err
);
  localparam int P   = 4 * DIV;
  localparam int PW  = $clog2(P);
  localparam int TMO = 6 * DIV;
  localparam int CW  = $clog2(TMO + 1);
  localparam logic [PW-1:0] Q1   = PW'(DIV);
  localparam logic [PW-1:0] Q3   = PW'(3 * DIV);
  localparam logic [PW-1:0] LAST = PW'(P - 1);
  localparam logic [CW-1:0] CMAX = CW'(TMO);
  localparam logic [CW-1:0] CTMO = CW'(TMO - 1);
  localparam logic [CW-1:0] HALF = CW'(2 * DIV);

  logic [PW-1:0] ph;
  logic          cur, idle;

  assign tx_ready = rst_n && (ph == LAST);
  assign tx_line  = (ph < Q1) || (cur && ph < Q3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= '0;
      cur  <= 1'b0;
      idle <= 1'b1;
    end else if (ph == LAST) begin
      ph <= '0;
      if (tx_valid) cur <= tx_data;
      else begin
        cur  <= idle;
        idle <= ~idle;
      end
    end else begin
      ph <= ph + 1'b1;
    end
  end

  logic          s0, s1, s2, seen;
  logic [CW-1:0] hi, gap;
  logic          rise, fall, tmo;

  assign rise = s1 & ~s2;
  assign fall = ~s1 & s2;
  assign tmo  = !rise && (gap == CTMO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {s0, s1, s2} <= '0;
      hi       <= '0;
      gap      <= '0;
      seen     <= 1'b0;
      rx_err   <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= 1'b0;
    end else begin
      s0 <= rx_line;
      s1 <= s0;
      s2 <= s1;
      if (rise)                  hi <= CW'(1);
      else if (s1 && hi != CMAX) hi <= hi + 1'b1;
      if (rise)             gap <= '0;
      else if (gap != CMAX) gap <= gap + 1'b1;
      if (rise)     begin seen <= 1'b1; rx_err <= 1'b0; end
      else if (tmo) begin seen <= 1'b0; rx_err <= 1'b1; end
      rx_valid <= fall && seen && !tmo;
      if (fall) rx_data <= (hi > HALF);
    end
  end
endmodule

module pmc_link_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_ready,
  input logic tx_line,
  input logic rx_valid,
  input logic rx_err
);
  assert_ready_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);
  assert_period_starts_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> tx_line);
  assert_rise_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_line) |-> $past(tx_ready));
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_no_decode_in_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> !rx_valid);
endmodule

bind pmc_link pmc_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .tx_line(tx_line),
  .rx_valid(rx_valid), .rx_err(rx_err)
);

// File: tb/sim_pmc_link.sv
module sim_pmc_link;
  localparam int DIV = 2;
  localparam int P   = 4 * DIV;

  logic clk = 0, rst_n = 0;
  logic tx_valid = 0, tx_data = 0;
  logic tx_ready, tx_line, rx_valid, rx_data, rx_err;
  logic brk = 0, dith = 0;
  logic rx_line;
  assign rx_line = brk ? 1'b0 : tx_line;

  pmc_link #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_line(tx_line), .rx_line(rx_line),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int m_ph, quiet, live;
  logic m_cur, m_idle, m_src_idle;
  logic q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cur = 0; m_idle = 1; m_src_idle = 1;
      q.delete(); q.push_back(1'b0);
      quiet = 0; live = 1000;
    end else begin
      if (m_ph == P - 1) begin
        if (tx_valid) begin m_cur = tx_data; m_src_idle = 0; end
        else begin m_cur = m_idle; m_idle = !m_idle; m_src_idle = 1; end
        m_ph = 0;
        if (!brk) q.push_back(m_cur);
      end else m_ph++;
      if (brk) begin quiet++; live = 0; end
      else begin quiet = 0; live++; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(tx_line == 1 && !tx_ready && !rx_valid && !rx_err, "R1",
          {tx_line, tx_ready, rx_valid, rx_err}, 4'b1000);
    end else begin
      logic exp_line;
      string tag;
      exp_line = (m_ph < DIV) || (m_cur && m_ph < 3 * DIV);
      tag = (m_ph < DIV) ? "R2" : (dith ? "R8" : (m_src_idle ? "R5" : "R3"));
      chk(tx_line == exp_line, tag, tx_line, exp_line);
      chk(tx_ready == (m_ph == P - 1), "R4", tx_ready, m_ph == P - 1);
      if (rx_valid) begin
        if (q.size() == 0) chk(0, "R6", rx_data, -1);
        else begin
          logic e;
          e = q.pop_front();
          chk(rx_data == e, "R6", rx_data, e);
        end
      end
      if (brk && quiet >= 8 * DIV + 4) chk(rx_err == 1, "R7", rx_err, 1);
      if (!brk && live >= P + 4)       chk(rx_err == 0, "R7", rx_err, 0);
    end
  end

  task automatic send(input logic b);
    @(negedge clk);
    tx_valid = 1; tx_data = b;
    while (!tx_ready) @(negedge clk);
    @(posedge clk); #1;
    tx_valid = 0;
  endtask

  task automatic wait_boundary();
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
  endtask

  initial begin
    logic [7:0] lfsr;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3 * P) @(negedge clk);
    for (int i = 0; i < 8; i++) send(1'b1);
    for (int i = 0; i < 8; i++) send(1'b0);
    for (int i = 0; i < 8; i++) send(i[0]);
    lfsr = 8'hA5;
    for (int i = 0; i < 24; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lfsr[1]) send(lfsr[0]);
      else repeat (P) @(negedge clk);
    end
    dith = 1;
    for (int i = 0; i < 6 * P; i++) begin
      @(negedge clk);
      tx_data = ~tx_data;
    end
    dith = 0;
    wait_boundary();
    brk = 1;
    repeat (5 * P) @(negedge clk);
    chk(rx_err == 1, "R7", rx_err, 1);
    wait_boundary();
    brk = 0;
    for (int i = 0; i < 6; i++) send(i[1]);
    repeat (3 * P) @(negedge clk);
    chk(q.size() <= 2, "R6", q.size(), 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule